// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the receive path of a bit-synchronous link, after the stage that finds flags and removes stuffed zero bits, and before the frame check stage. Each input beat is either a flag indication or one data byte. The filter finds frame boundaries from the flags. It reads the 16-bit address that opens each frame and compares that address with four programmable address registers under one shared mask. A frame whose address matches passes downstream in full, address bytes included, with start and end markers and the index of the register that matched. A frame that does not match produces no output.

Output is one byte behind the input. The filter has to hold the first address byte until the second one arrives and the match is known. After that it keeps a one-byte lag register, so the last byte of a frame can be tagged as the end when the closing flag arrives. A single flag between two frames closes the first frame and opens the second.

States: `ST_HUNT` (enabled, waiting for any flag; data ignored), `ST_IDLE` (a flag has been seen and the frame has no data yet), `ST_ADDR2` (first address byte stored, waiting for the second), `ST_PASS` (address matched, bytes forwarded), `ST_DROP` (address missed, bytes discarded). Transitions: HUNT->IDLE on a flag; IDLE->IDLE on a flag (idle fill); IDLE->ADDR2 on data; ADDR2->IDLE on a flag (short frame dropped); ADDR2->PASS on data with a hit; ADDR2->DROP on data with a miss; PASS->IDLE and DROP->IDLE on a flag; any state ->HUNT while `enable` is low.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `out_eof` are 0 and `out_idx` is 0.
- R2: After `enable` rises, data beats are ignored until the first flag beat. No output results from them, even if they form a matching address.
- R3: Register i is taken from `cfg_addr[16*i+15:16*i]`. A frame is accepted when `(rx_addr & cfg_mask) == (reg_i & cfg_mask)` for some i. A mask bit of 1 means the bit is compared; a mask of 0 accepts every frame.
- R4: `out_idx` gives the lowest-numbered matching register. It is held constant on every output beat of the frame.
- R5: With `cfg_mask` all ones, a register holding 16'hFFFF accepts frames addressed 16'hFFFF (broadcast).
- R6: The address is built from the first two data bytes after the opening flag. The first byte is bits 7:0 and the second byte is bits 15:8.
- R7: An accepted frame's bytes leave in order, starting with the first address byte. `out_sof` marks the first byte and `out_eof` marks the last. Byte k (counted from 0) leaves one clock after the input beat that carries byte k+1, or after the closing flag when k is the last byte.
- R8: A frame whose address matches no register produces no output.
- R9: A frame closed by a flag before two data bytes arrive produces no output.
- R10: Consecutive flags with no data between them produce no output and create no empty frame.
- R11: One flag between two frames closes the first frame (its `out_eof`) and opens the second, and both frames are filtered normally.
- R12: Deasserting `enable` abandons any frame in progress with no further output and no `out_eof`. When `enable` rises again, hunting starts anew as in R2.
- R13: A cycle with `in_valid` low changes nothing and produces no output. Each output byte is a one-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low forces the hunt state |
| cfg_addr | input | NUM_ADDR*16 | Packed address registers, register i in bits 16*i+15:16*i |
| cfg_mask | input | 16 | Shared compare mask, 1 = bit compared |
| in_valid | input | 1 | Input beat present |
| in_flag | input | 1 | Beat is a flag (in_data ignored) |
| in_data | input | 8 | Data byte of a non-flag beat |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First byte of an accepted frame |
| out_eof | output | 1 | Last byte of an accepted frame |
| out_idx | output | IDX_W | Lowest matching address register index |
| out_data | output | 8 | Forwarded byte |

## Verification
The closing of one frame and the opening of the next fall on the same flag beat. On that clock the lag register must release the previous frame's last byte tagged `out_eof`, while the state machine re-arms for a new address. The bench drives long runs of frames with exactly one flag between them. Their addresses alternate between hits and misses, their lengths vary, and short frames (zero or one byte) are mixed in. For every frame it compares the recorded output beats, their markers, index and arrival positions against a model built from the mask and the register values. A slip at the shared flag shows up as a lost end marker, a lost start, or a stray byte carried into the next frame's record.

// File: rtl/hafilt_pkg.sv
package hafilt_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_IDLE,
        ST_ADDR2,
        ST_PASS,
        ST_DROP
    } hafilt_state_e;

endpackage

// File: rtl/hafilt_match.sv
module hafilt_match #(
    parameter int ADDR_W   = 16,
    parameter int NUM_ADDR = 4,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0]          rx_addr,
    input  logic [ADDR_W-1:0]          mask,
    input  logic [NUM_ADDR*ADDR_W-1:0] table_flat,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx
);

    logic [NUM_ADDR-1:0] hit_vec;

    // One masked comparator per address register
    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
        assign hit_vec[g] =
            ((rx_addr ^ table_flat[g*ADDR_W +: ADDR_W]) & mask) == '0;
    end

    assign hit = |hit_vec;

    // Lowest index wins: scan downward so the last write is the lowest hit
    always_comb begin
        idx = '0;
        for (int i = NUM_ADDR - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hafilt_lag.sv
module hafilt_lag #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hafilt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_ADDR = 4,
    localparam int ADDR_W  = 2 * DATA_W,
    localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [NUM_ADDR*ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]          cfg_mask,
    input  logic                       in_valid,
    input  logic                       in_flag,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    output logic                       out_sof,
    output logic                       out_eof,
    output logic [IDX_W-1:0]           out_idx,
    output logic [DATA_W-1:0]          out_data
);

    hafilt_state_e state_q, state_d;

    logic              beat_flag;
    logic              beat_data;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hold_q;
    logic              addr_hit;
    logic [IDX_W-1:0]  addr_idx;
    logic              take_lo;
    logic              take_hold;
    logic              accept;

    assign beat_flag = enable && in_valid && in_flag;
    assign beat_data = enable && in_valid && !in_flag;

    assign accept    = (state_q == ST_ADDR2) && beat_data && addr_hit;
    assign take_lo   = (state_q == ST_IDLE) && beat_data;
    assign take_hold = accept || ((state_q == ST_PASS) && beat_data);

    hafilt_match #(
        .ADDR_W   (ADDR_W),
        .NUM_ADDR (NUM_ADDR),
        .IDX_W    (IDX_W)
    ) u_match (
        .rx_addr    ({in_data, lo_q}),
        .mask       (cfg_mask),
        .table_flat (cfg_addr),
        .hit        (addr_hit),
        .idx        (addr_idx)
    );

    hafilt_lag #(.W(DATA_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take_lo),
        .d     (in_data),
        .q     (lo_q)
    );

    hafilt_lag #(.W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take_hold),
        .d     (in_data),
        .q     (hold_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (beat_flag) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (beat_data) state_d = ST_ADDR2;
                end
                ST_ADDR2: begin
                    if (beat_flag) begin
                        state_d = ST_IDLE;
                    end else if (beat_data) begin
                        state_d = addr_hit ? ST_PASS : ST_DROP;
                    end
                end
                ST_PASS: begin
                    if (beat_flag) state_d = ST_IDLE;
                end
                ST_DROP: begin
                    if (beat_flag) state_d = ST_IDLE;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_idx   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            unique case (state_q)
                ST_ADDR2: begin
                    if (accept) begin
                        out_valid <= 1'b1;
                        out_sof   <= 1'b1;
                        out_idx   <= addr_idx;
                        out_data  <= lo_q;
                    end
                end
                ST_PASS: begin
                    if (beat_data || beat_flag) begin
                        out_valid <= 1'b1;
                        out_eof   <= beat_flag;
                        out_data  <= hold_q;
                    end
                end
                ST_HUNT, ST_IDLE, ST_DROP: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/hafilt_checker.sv
module hafilt_checker #(
    parameter int NUM_ADDR = 4,
    localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             in_valid,
    input logic             in_flag,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic [IDX_W-1:0] out_idx
);

    logic             seen_flag;
    logic             in_frame;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_flag <= 1'b0;
            in_frame  <= 1'b0;
            last_idx  <= '0;
        end else begin
            if (!enable) begin
                seen_flag <= 1'b0;
            end else if (in_valid && in_flag) begin
                seen_flag <= 1'b1;
            end
            if (!enable) begin
                in_frame <= 1'b0;
            end else if (out_valid && out_eof) begin
                in_frame <= 1'b0;
            end else if (out_valid && out_sof) begin
                in_frame <= 1'b1;
            end
            if (out_valid) begin
                last_idx <= out_idx;
            end
        end
    end

    a_r2_hunt_ignores_data: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && in_valid && !in_flag && !seen_flag) |=> !out_valid);

    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid);

    a_r13_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_flag_only_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && in_valid && in_flag) |=> (!out_valid || out_eof));

    a_r7_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    a_r9_sof_not_eof: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> !out_eof);

    a_r7_sof_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> !in_frame);

    a_r10_no_byte_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> in_frame);

    a_r4_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> (out_idx == last_idx));

    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_idx) < NUM_ADDR));

endmodule

bind hdlc_addr_filter hafilt_checker #(.NUM_ADDR(NUM_ADDR)) u_hafilt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_valid  (in_valid),
    .in_flag   (in_flag),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_idx   (out_idx)
);

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;

    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [NA*16-1:0] cfg_addr = '0;
    logic [15:0]   cfg_mask = '0;
    logic          in_valid = 1'b0;
    logic          in_flag = 1'b0;
    logic [7:0]    in_data = '0;
    logic          out_valid, out_sof, out_eof;
    logic [1:0]    out_idx;
    logic [7:0]    out_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] fbuf [16];
    logic [7:0] cap_data [64];
    logic       cap_sof [64];
    logic       cap_eof [64];
    logic [1:0] cap_idx [64];
    int         cap_pos [64];
    int         cap_n = 0;
    int         pos_ctr = 0;
    logic [15:0] areg [NA];

    always #5 clk = ~clk;

    hdlc_addr_filter #(.DATA_W(8), .NUM_ADDR(NA)) i_hdlc_addr_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_addr  (cfg_addr),
        .cfg_mask  (cfg_mask),
        .in_valid  (in_valid),
        .in_flag   (in_flag),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_idx   (out_idx),
        .out_data  (out_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Apply one beat, wait one edge, record any output beat
    task automatic beat(input bit v, input bit f, input logic [7:0] d);
        in_valid = v;
        in_flag  = f;
        in_data  = d;
        @(posedge clk);
        #1;
        if (out_valid && cap_n < 64) begin
            cap_data[cap_n] = out_data;
            cap_sof[cap_n]  = out_sof;
            cap_eof[cap_n]  = out_eof;
            cap_idx[cap_n]  = out_idx;
            cap_pos[cap_n]  = pos_ctr;
            cap_n = cap_n + 1;
        end
        if (v) pos_ctr = pos_ctr + 1;
        in_valid = 1'b0;
        in_flag  = 1'b0;
    endtask

    function automatic int exp_idx(input logic [15:0] a);
        for (int i = 0; i < NA; i++) begin
            if (((a ^ areg[i]) & cfg_mask) == 16'h0) return i;
        end
        return NA;
    endfunction

    task automatic load_cfg(input logic [15:0] m);
        cfg_mask = m;
        for (int i = 0; i < NA; i++) cfg_addr[i*16 +: 16] = areg[i];
    endtask

    // Send fbuf[0..len-1] then one closing flag, then compare with the model
    task automatic send_frame(input int len, input int gap_at, input string tag);
        int  ei;
        int  en;
        int  bad;
        pos_ctr = 0;
        cap_n   = 0;
        for (int k = 0; k < len; k++) begin
            if (k == gap_at) beat(1'b0, 1'b0, 8'hA5);
            beat(1'b1, 1'b0, fbuf[k]);
        end
        beat(1'b1, 1'b1, 8'h7E);
        ei  = (len >= 2) ? exp_idx({fbuf[1], fbuf[0]}) : NA;
        en  = (len >= 2 && ei < NA) ? len : 0;
        bad = -1;
        if (cap_n == en) begin
            for (int k = 0; k < en; k++) begin
                if (bad < 0 && (cap_data[k] !== fbuf[k] || cap_sof[k] !== (k == 0) ||
                    cap_eof[k] !== (k == en - 1) || int'(cap_idx[k]) != ei ||
                    cap_pos[k] != k + 1)) bad = k;
            end
        end
        check(cap_n == en, {tag, " beat count"}, cap_n, en);
        if (cap_n == en && en > 0)
            check(bad < 0, {tag, " beat content/idx/position, first bad beat"}, bad, -1);
    endtask

    initial begin
        areg[0] = 16'h1234;
        areg[1] = 16'h1204;
        areg[2] = 16'hABCD;
        areg[3] = 16'hFFFF;
        load_cfg(16'hFF0F);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid === 1'b0 && out_sof === 1'b0 && out_eof === 1'b0,
              "R1 flags at reset", {out_valid, out_sof, out_eof}, 0);
        check(out_idx === 2'd0, "R1 idx at reset", out_idx, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        enable = 1'b1;

        // R2: matching bytes before any flag are ignored; R10: flag runs are idle
        pos_ctr = 0;
        cap_n   = 0;
        beat(1'b1, 1'b0, 8'h34);
        beat(1'b1, 1'b0, 8'h12);
        beat(1'b1, 1'b0, 8'h55);
        beat(1'b1, 1'b1, 8'h7E);
        check(cap_n == 0, "R2 hunt ignores data", cap_n, 0);
        beat(1'b1, 1'b1, 8'h7E);
        beat(1'b1, 1'b1, 8'h7E);
        beat(1'b1, 1'b1, 8'h7E);
        check(cap_n == 0, "R10 idle flags", cap_n, 0);

        // Sweep: R3 R4 R5 R6 R7 R8 R9 R10 R11 R13, frames back-to-back on one flag
        for (int m = 0; m < 3; m++) begin
            load_cfg((m == 0) ? 16'hFF0F : (m == 1) ? 16'hFFFF : 16'h0000);
            for (int h = 0; h < 4; h++) begin
                for (int l = 0; l < 16; l++) begin
                    int len;
                    logic [7:0] lo;
                    logic [7:0] hi;
                    hi = (h == 0) ? 8'h12 : (h == 1) ? 8'hAB : (h == 2) ? 8'hFF : 8'h00;
                    case (l)
                        0: lo = 8'h34;
                        1: lo = 8'h04;
                        2: lo = 8'hCD;
                        4: lo = 8'hF4;
                        5: lo = 8'hFF;
                        default: lo = 8'(l * 17);
                    endcase
                    len = 2 + ((l + h) % 4);
                    if (l == 3) len = 1;
                    if (l == 7) len = 0;
                    fbuf[0] = lo;
                    fbuf[1] = hi;
                    for (int j = 2; j < 16; j++) fbuf[j] = 8'(l * 8 + j + m);
                    send_frame(len, (l % 5 == 0) ? (l % 3) + 1 : -1,
                               "R3 R4 R5 R6 R7 R8 R9 R11 R13 sweep");
                end
            end
        end

        // R5: broadcast with full mask, only register 3 holds all ones
        load_cfg(16'hFFFF);
        fbuf[0] = 8'hFF; fbuf[1] = 8'hFF; fbuf[2] = 8'h01;
        send_frame(3, -1, "R5 broadcast");
        fbuf[0] = 8'hFE; fbuf[1] = 8'hFF;
        send_frame(3, -1, "R5 near-broadcast rejected R8");
        // R6: swapped byte order of register 2 must not match
        fbuf[0] = 8'hAB; fbuf[1] = 8'hCD;
        send_frame(2, -1, "R6 byte order");

        // R12: disable mid-frame abandons it without eof
        pos_ctr = 0;
        cap_n   = 0;
        beat(1'b1, 1'b0, 8'h34);
        beat(1'b1, 1'b0, 8'h12);
        beat(1'b1, 1'b0, 8'h77);
        enable = 1'b0;
        beat(1'b1, 1'b0, 8'h78);
        beat(1'b1, 1'b1, 8'h7E);
        check(cap_n == 2, "R12 beats before disable", cap_n, 2);
        check(cap_n == 2 && cap_eof[1] === 1'b0, "R12 no eof on abandoned frame",
              (cap_n == 2) ? int'(cap_eof[1]) : -1, 0);
        enable = 1'b1;
        cap_n  = 0;
        beat(1'b1, 1'b0, 8'h34);
        beat(1'b1, 1'b0, 8'h12);
        beat(1'b1, 1'b0, 8'h99);
        check(cap_n == 0, "R12 hunt after re-enable", cap_n, 0);
        beat(1'b1, 1'b1, 8'h7E);
        fbuf[0] = 8'h34; fbuf[1] = 8'h12; fbuf[2] = 8'h42;
        send_frame(3, -1, "R12 normal frame after re-enable");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule